// File: doc/BRIEF.md
# Aligned Free Thread-Window Locator

This block keeps a register with one occupancy bit per hardware thread slot. It finds where a new thread block can be placed in that register. The request is an unpadded thread count. The block rounds the count up to a whole number of warps, giving the window size P. It then tests only the windows that start at 0, P, 2P and so on. It reports the lowest-numbered window whose P slots are all idle, together with a found flag. Windows at other offsets are never tested, even if they are free.

The block also updates the occupancy register:
- A launch pulse marks a block as placed. When a window is found, it sets exactly the requested number of slots from the reported start. The rounding slots at the end of the window stay idle.
- An exit pulse clears one slot.

The search is combinational from the registered occupancy and the request. The updates take effect at the next clock edge.

Top module: `slot_window_finder`

## Requirements
- R1: After reset is asserted (active low), every bit of `active_slots` is 0.
- R2: `pad_size` equals `req_threads` rounded up to the next multiple of WARP (defaults: 64 slots, WARP 8), so 1→8, 8→8, 9→16 and 0→0.
- R3: A window may only start at an integer multiple of `pad_size`. A free window at any other offset is never reported.
- R4: A window is accepted only when all `pad_size` slots in it are idle in `active_slots`. Among accepted windows, the one with the lowest start is reported.
- R5: A window whose end would pass the last slot is not free. When no window is accepted, `found` is 0 and `start_slot` is 0.
- R6: A request of zero threads gives `found` = 0.
- R7: A `launch` pulse in a cycle with `found` = 1 sets slots `start_slot` through `start_slot + req_threads - 1` at the next edge. The rounding slots beyond that range are left clear.
- R8: An `exit_en` pulse clears bit `exit_slot` of `active_slots` at the next edge. No other bit changes.
- R9: A `launch` pulse in a cycle with `found` = 0 leaves `active_slots` unchanged.
- R10: A launch and an exit in the same cycle are both applied at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_threads | input | $clog2(NUM_SLOTS+1) | Unpadded thread count of the block to place |
| launch | input | 1 | Mark the found window as occupied |
| exit_en | input | 1 | Clear one slot |
| exit_slot | input | $clog2(NUM_SLOTS) | Slot cleared by `exit_en` |
| found | output | 1 | An aligned free window exists |
| start_slot | output | $clog2(NUM_SLOTS) | First slot of the chosen window, 0 when none |
| pad_size | output | $clog2(NUM_SLOTS+1)+1 | Warp-rounded window size |
| active_slots | output | NUM_SLOTS | Registered occupancy vector |

## Verification
The bench steps the occupancy through three stages:
- An empty vector, where every request lands at slot 0.
- A partly filled vector, where a 16-thread request must land at 16 and not at the free slot 8. This separates aligned search from search at every offset.
- A vector where the only aligned start that is still open would overrun the end. This separates a correct fit test from one that lets the window wrap or spill over.

Exit pulses then clear a block slot by slot. A later request for 9 threads lands at slot 0. This shows that the rounding slots of the earlier block were never marked. A final cycle with both a launch and an exit separates a design that applies both updates from one that applies only one.

// File: rtl/slot_pkg.sv
package slot_pkg;

    // True when a is a whole multiple of a nonzero step b.
    function automatic logic on_grid(input int a, input int b);
        if (b == 0) return 1'b0;
        return (a % b) == 0;
    endfunction

endpackage

// File: rtl/slot_pad_calc.sv
module slot_pad_calc #(
    parameter int WARP  = 8,
    parameter int CNT_W = 7,
    parameter int PAD_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [PAD_W-1:0] padded,
    output logic [PAD_W-1:0] warps
);
    int nw;
    always_comb begin
        nw     = (int'(cnt) + WARP - 1) / WARP;
        warps  = PAD_W'(nw);
        padded = PAD_W'(nw * WARP);
    end
endmodule

// File: rtl/slot_window_check.sv
module slot_window_check
    import slot_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int WARP      = 8,
    parameter int PAD_W     = 8,
    parameter int IDX       = 0
) (
    input  logic [NUM_SLOTS-1:0] active,
    input  logic [PAD_W-1:0]     padded,
    input  logic [PAD_W-1:0]     warps,
    output logic                 ok
);
    localparam int START = IDX * WARP;

    logic busy;
    logic aligned;
    logic fits;

    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i >= START && i < START + int'(padded) && active[i])
                busy = 1'b1;
        end
        aligned = on_grid(IDX, int'(warps));
        fits    = (START + int'(padded)) <= NUM_SLOTS;
        ok      = aligned && fits && !busy;
    end
endmodule

// File: rtl/slot_first_pick.sv
module slot_first_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/slot_window_finder.sv
module slot_window_finder #(
    parameter int NUM_SLOTS = 64,
    parameter int WARP      = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
    localparam int PAD_W    = CNT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     req_threads,
    input  logic                 launch,
    input  logic                 exit_en,
    input  logic [SLOT_W-1:0]    exit_slot,
    output logic                 found,
    output logic [SLOT_W-1:0]    start_slot,
    output logic [PAD_W-1:0]     pad_size,
    output logic [NUM_SLOTS-1:0] active_slots
);
    localparam int NCAND  = NUM_SLOTS / WARP;
    localparam int CAND_W = (NCAND > 1) ? $clog2(NCAND) : 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] active;
    } state_t;

    state_t st_d, st_q;

    logic [PAD_W-1:0]  warps;
    logic [NCAND-1:0]  cand_ok;
    logic [CAND_W-1:0] pick;
    logic              any_ok;

    slot_pad_calc #(.WARP(WARP), .CNT_W(CNT_W), .PAD_W(PAD_W)) u_pad (
        .cnt    (req_threads),
        .padded (pad_size),
        .warps  (warps)
    );

    for (genvar j = 0; j < NCAND; j++) begin : g_cand
        slot_window_check #(
            .NUM_SLOTS(NUM_SLOTS), .WARP(WARP), .PAD_W(PAD_W), .IDX(j)
        ) u_chk (
            .active (st_q.active),
            .padded (pad_size),
            .warps  (warps),
            .ok     (cand_ok[j])
        );
    end

    slot_first_pick #(.N(NCAND), .IDX_W(CAND_W)) u_pick (
        .req (cand_ok),
        .any (any_ok),
        .idx (pick)
    );

    always_comb begin
        found      = any_ok;
        start_slot = any_ok ? SLOT_W'(int'(pick) * WARP) : '0;
    end

    always_comb begin
        st_d = st_q;
        if (exit_en)
            st_d.active[exit_slot] = 1'b0;
        if (launch && found) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (i >= int'(start_slot) && i < int'(start_slot) + int'(req_threads))
                    st_d.active[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_slots = st_q.active;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> active_slots == '0); // R1
    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (int'(start_slot) % int'(pad_size)) == 0); // R3
    AST_WINDOW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((active_slots >> start_slot) & ~({NUM_SLOTS{1'b1}} << pad_size)) == '0); // R4
    AST_WINDOW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> int'(start_slot) + int'(pad_size) <= NUM_SLOTS); // R5
    AST_ZERO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_threads == '0 |-> !found); // R6
    AST_LAUNCH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        launch && found |=> active_slots[$past(start_slot)]); // R7
    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        exit_en && !launch |=> !active_slots[$past(exit_slot)]); // R8
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !found && !exit_en |=> $stable(active_slots)); // R9
endmodule

// File: tb/slot_window_finder_test.sv
`timescale 1ns/1ps
module slot_window_finder_test;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    req_threads = '0;
    logic          launch = 1'b0;
    logic          exit_en = 1'b0;
    logic [5:0]    exit_slot = '0;
    logic          found;
    logic [5:0]    start_slot;
    logic [7:0]    pad_size;
    logic [NS-1:0] active_slots;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    slot_window_finder #(.NUM_SLOTS(NS), .WARP(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_threads(req_threads), .launch(launch),
        .exit_en(exit_en), .exit_slot(exit_slot), .found(found),
        .start_slot(start_slot), .pad_size(pad_size), .active_slots(active_slots)
    );

    typedef struct packed {
        logic [1:0]    op;   // 0 query, 1 launch, 2 exit
        logic [6:0]    cnt;
        logic [5:0]    idx;
        logic          f;
        logic [5:0]    s;
        logic [NS-1:0] act;  // occupancy expected before this row's edge
    } vec_t;

    localparam logic [NS-1:0] A1 = 64'h0000_0000_0000_001F;
    localparam logic [NS-1:0] A2 = 64'h0000_0000_FFFF_001F;

    localparam vec_t TBL [0:16] = '{
        '{2'd0, 7'd5,  6'd0, 1'b1, 6'd0,  64'h0},   // R4 empty vector
        '{2'd1, 7'd5,  6'd0, 1'b1, 6'd0,  64'h0},   // R7 place 5 at 0
        '{2'd0, 7'd8,  6'd0, 1'b1, 6'd8,  A1},      // R4 lowest free
        '{2'd0, 7'd16, 6'd0, 1'b1, 6'd16, A1},      // R3 aligned, not 8
        '{2'd1, 7'd16, 6'd0, 1'b1, 6'd16, A1},      // R7 place 16 at 16
        '{2'd0, 7'd3,  6'd0, 1'b1, 6'd8,  A2},      // R4
        '{2'd0, 7'd20, 6'd0, 1'b0, 6'd0,  A2},      // R5 48+24 overruns
        '{2'd1, 7'd20, 6'd0, 1'b0, 6'd0,  A2},      // R9 launch on miss
        '{2'd0, 7'd64, 6'd0, 1'b0, 6'd0,  A2},      // R9 state held, R5
        '{2'd0, 7'd0,  6'd0, 1'b0, 6'd0,  A2},      // R6 zero count
        '{2'd2, 7'd0,  6'd0, 1'b0, 6'd0,  A2},      // R8
        '{2'd2, 7'd0,  6'd1, 1'b0, 6'd0,  64'h0000_0000_FFFF_001E},
        '{2'd2, 7'd0,  6'd2, 1'b0, 6'd0,  64'h0000_0000_FFFF_001C},
        '{2'd2, 7'd0,  6'd3, 1'b0, 6'd0,  64'h0000_0000_FFFF_0018},
        '{2'd2, 7'd0,  6'd4, 1'b0, 6'd0,  64'h0000_0000_FFFF_0010},
        '{2'd0, 7'd9,  6'd0, 1'b1, 6'd0,  64'h0000_0000_FFFF_0000}, // R7 pad slots unmarked
        '{2'd0, 7'd32, 6'd0, 1'b1, 6'd32, 64'h0000_0000_FFFF_0000}  // R3 R4
    };

    task automatic check(input string req, input logic [NS-1:0] got, input logic [NS-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset", active_slots, '0);

        foreach (TBL[k]) begin
            @(negedge clk);
            req_threads = TBL[k].cnt;
            launch      = (TBL[k].op == 2'd1);
            exit_en     = (TBL[k].op == 2'd2);
            exit_slot   = TBL[k].idx;
            #1;
            check($sformatf("R4 found row %0d", k), NS'(found), NS'(TBL[k].f));
            check($sformatf("R5 start row %0d", k), NS'(start_slot), NS'(TBL[k].s));
            check($sformatf("R8 active row %0d", k), active_slots, TBL[k].act);
        end

        // R2 rounding
        @(negedge clk);
        launch = 1'b0; exit_en = 1'b0;
        req_threads = 7'd1;  #1; check("R2 pad 1",  NS'(pad_size), NS'(8));
        req_threads = 7'd8;  #1; check("R2 pad 8",  NS'(pad_size), NS'(8));
        req_threads = 7'd9;  #1; check("R2 pad 9",  NS'(pad_size), NS'(16));
        req_threads = 7'd0;  #1; check("R2 pad 0",  NS'(pad_size), NS'(0));

        // R10 launch of 8 at slot 0 together with exit of slot 20
        @(negedge clk);
        req_threads = 7'd8; launch = 1'b1; exit_en = 1'b1; exit_slot = 6'd20;
        #1;
        check("R10 start", NS'(start_slot), NS'(0));
        @(negedge clk);
        launch = 1'b0; exit_en = 1'b0;
        #1;
        check("R10 both applied", active_slots, 64'h0000_0000_FFEF_00FF);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset again", active_slots, '0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule